// File: doc/BRIEF.md
# Coprocessor Bus Request and Reset Control

This block sits on the main processor's bus as a byte-wide register target. It owns two control lines that go to a secondary 8-bit processor: a bus request, which asks that processor to let go of its bus, and an active-low reset. The main processor sets both lines by writing one bit at a fixed control offset. It can read back the grant state and the reset state. A read at offset 0 returns a fixed version byte that reports the console's region strapping.

The block also guards the 64 KB window through which the main processor reaches the secondary processor's memory. Any access to that window takes one extra wait cycle. The access goes through to the window only if the secondary processor had granted its bus (busack high) when the access started. Without the grant, a write is dropped and a read returns all ones.

The address is 17 bits wide. When bit 16 is 0 the access targets the window, which covers addresses below 0x10000. When bit 16 is 1 the access targets the register space, and the register offset is bits 12:0.

Top module: `cop_ctl`

## Requirements
- R1: While rst_n is low at a clock edge, the next cycle shows cop_busreq = 0, cop_reset_n = 0 (reset asserted), cpu_wait = 0 and no window strobe.
- R2: A write to register offset 0x1100 loads the selected data bit into cop_busreq: 1 requests the bus and 0 releases it. The new value shows in the cycle after the strobe.
- R3: A write to register offset 0x1200 loads the selected data bit into cop_reset_n: 0 holds the secondary processor in reset and 1 lets it run. The new value shows in the cycle after the strobe.
- R4: The selected data bit and byte follow cpu_word. A byte access (cpu_word = 0) uses cpu_wdata[7:0], so the control bit is bit 0. A word access (cpu_word = 1) uses cpu_wdata[15:8], so the control bit is bit 8.
- R5: A read at offset 0x1100 returns, in the following cycle, the inverse of cop_busack in bit 0 and open_bus[7:1] in bits 7:1. Both are sampled at the strobe edge.
- R6: A read at offset 0x1200 returns {7'b0, cop_reset_n}.
- R7: A read at offset 0 or 1 returns the version byte. Bit 7 is the export flag, bit 6 the 50 Hz flag and bit 5 the no-expansion flag; bits 4:0 are 0. With the default parameters the byte is 0xA0.
- R8: A read at any other register offset returns 0xFF. A write to any other register offset leaves cop_busreq and cop_reset_n unchanged.
- R9: Address bits 15:13 play no part in register decoding. For example, 0x1F100 acts exactly like 0x11100.
- R10: A strobe to the window raises cpu_wait for exactly the next cycle. Strobes seen while cpu_wait is high are ignored.
- R11: If cop_busack was high at the strobe edge, the wait cycle carries win_rd or win_wr with win_addr = cpu_addr[15:0] and win_wdata holding the byte selected under R4. A read then returns win_rdata, sampled at the end of the wait cycle, in the cycle after the wait.
- R12: If cop_busack was low at the strobe edge, no window strobe is issued and a read returns 0xFF in the cycle after the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 17 | Bit 16 selects register space (1) or window (0); bits 15:0 are the offset |
| cpu_wdata | input | 16 | Write data |
| cpu_word | input | 1 | 1 for a word access (upper byte used) |
| cpu_rd | input | 1 | Single-cycle read strobe |
| cpu_wr | input | 1 | Single-cycle write strobe |
| cop_busack | input | 1 | Bus grant from the secondary processor |
| open_bus | input | 8 | Floating-bus byte used in the bus-request read-back |
| win_rdata | input | 8 | Read data from the window target |
| cop_busreq | output | 1 | Bus request to the secondary processor |
| cop_reset_n | output | 1 | Active-low reset to the secondary processor |
| cpu_rdata | output | 8 | Registered read data |
| cpu_wait | output | 1 | Wait request during a window access |
| win_rd | output | 1 | Granted window read strobe |
| win_wr | output | 1 | Granted window write strobe |
| win_addr | output | 16 | Window address |
| win_wdata | output | 8 | Window write byte |

## Verification
A register write changes cop_busreq or cop_reset_n one edge after the strobe. A register read loads cpu_rdata at that same edge. The bench drives strobes on falling edges and samples on the falling edge that follows, so it sees the registered value with no race. A window access takes two edges: the first opens the wait cycle, which is checked for cpu_wait and the window strobes, and the second loads the read data, which is checked one falling edge later. The bench samples cop_busack and open_bus when it launches an access and holds them steady until the result has been checked.

// File: rtl/cop_ctl_pkg.sv
// Package: shared selection type for the coprocessor control block.
// Assumes one register target is selected per access.
package cop_ctl_pkg;

    typedef enum logic [2:0] {
        SEL_WIN     = 3'd0,
        SEL_VERSION = 3'd1,
        SEL_BUSREQ  = 3'd2,
        SEL_RESET   = 3'd3,
        SEL_NONE    = 3'd4
    } sel_e;

endpackage

// File: rtl/cop_ctl_decode.sv
// Module: address decoder. Bit 16 picks window versus register space.
// Inside register space only the low offset bits are compared.
// Assumes the offsets are distinct and lie at or above the version span.
module cop_ctl_decode
    import cop_ctl_pkg::*;
#(
    parameter int                  OFS_W      = 13,
    parameter logic [OFS_W-1:0]    BUSREQ_OFS = 13'h1100,
    parameter logic [OFS_W-1:0]    RESET_OFS  = 13'h1200
) (
    input  logic             reg_space,
    input  logic [OFS_W-1:0] ofs,
    output sel_e             sel
);
    // decode the target of the current access
    always_comb begin
        if (!reg_space) begin
            sel = SEL_WIN;
        end else if (ofs == BUSREQ_OFS) begin
            sel = SEL_BUSREQ;
        end else if (ofs == RESET_OFS) begin
            sel = SEL_RESET;
        end else if (ofs[OFS_W-1:1] == '0) begin
            sel = SEL_VERSION;
        end else begin
            sel = SEL_NONE;
        end
    end
endmodule

// File: rtl/cop_ctl_regs.sv
// Module: holds the two control lines for the secondary processor.
// On reset, the bus request is released and reset is asserted.
module cop_ctl_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic ld_busreq,
    input  logic ld_reset,
    input  logic bit_in,
    output logic busreq,
    output logic reset_n
);
    // load the control flops from the selected write bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busreq  <= 1'b0;
            reset_n <= 1'b0;
        end else begin
            if (ld_busreq) busreq  <= bit_in;
            if (ld_reset)  reset_n <= bit_in;
        end
    end
endmodule

// File: rtl/cop_ctl_window.sv
// Module: gates main-processor accesses into the secondary window.
// It captures the access and the grant at the strobe edge and holds
// a wait for one cycle, in which the granted strobe is issued.
// Assumes no new start arrives while the wait is high.
module cop_ctl_window #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_rd,
    input  logic          start_wr,
    input  logic [AW-1:0] start_addr,
    input  logic [DW-1:0] start_data,
    input  logic          busack,
    input  logic [DW-1:0] win_rdata,
    output logic          cpu_wait,
    output logic          win_rd,
    output logic          win_wr,
    output logic [AW-1:0] win_addr,
    output logic [DW-1:0] win_wdata,
    output logic          rd_done,
    output logic [DW-1:0] rd_data
);
    logic          pend_q;
    logic          pend_wr_q;
    logic          grant_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;

    // capture an access and its grant, then keep it open for one wait cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= 1'b0;
            pend_wr_q <= 1'b0;
            grant_q   <= 1'b0;
            addr_q    <= '0;
            data_q    <= '0;
        end else if (start_rd || start_wr) begin
            pend_q    <= 1'b1;
            pend_wr_q <= start_wr;
            grant_q   <= busack;
            addr_q    <= start_addr;
            data_q    <= start_data;
        end else begin
            pend_q    <= 1'b0;
        end
    end

    assign cpu_wait  = pend_q;
    assign win_rd    = pend_q && !pend_wr_q && grant_q;
    assign win_wr    = pend_q &&  pend_wr_q && grant_q;
    assign win_addr  = addr_q;
    assign win_wdata = data_q;
    assign rd_done   = pend_q && !pend_wr_q;
    assign rd_data   = grant_q ? win_rdata : {DW{1'b1}};
endmodule

// File: rtl/cop_ctl.sv
// Module: register block for the coprocessor's bus request and reset.
// Byte-wide control and read-back on the main bus, a version byte,
// and a gated window into the coprocessor's memory.
// Assumes single-cycle strobes and no new strobe while cpu_wait is high.
module cop_ctl
    import cop_ctl_pkg::*;
#(
    parameter int                 ADDR_W     = 17,
    parameter int                 OFS_W      = 13,
    parameter int                 DATA_W     = 16,
    parameter logic [OFS_W-1:0]   BUSREQ_OFS = 13'h1100,
    parameter logic [OFS_W-1:0]   RESET_OFS  = 13'h1200,
    parameter bit                 VER_EXPORT = 1'b1,
    parameter bit                 VER_PAL    = 1'b0,
    parameter bit                 VER_NO_EXP = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [DATA_W-1:0]       cpu_wdata,
    input  logic                    cpu_word,
    input  logic                    cpu_rd,
    input  logic                    cpu_wr,
    input  logic                    cop_busack,
    input  logic [DATA_W/2-1:0]     open_bus,
    input  logic [DATA_W/2-1:0]     win_rdata,
    output logic                    cop_busreq,
    output logic                    cop_reset_n,
    output logic [DATA_W/2-1:0]     cpu_rdata,
    output logic                    cpu_wait,
    output logic                    win_rd,
    output logic                    win_wr,
    output logic [ADDR_W-2:0]       win_addr,
    output logic [DATA_W/2-1:0]     win_wdata
);
    localparam int BW  = DATA_W / 2;
    localparam int WAW = ADDR_W - 1;
    localparam logic [BW-1:0] VERSION_BYTE =
        {VER_EXPORT, VER_PAL, VER_NO_EXP, {(BW-3){1'b0}}};

    sel_e          sel;
    logic          acc_rd;
    logic          acc_wr;
    logic [BW-1:0] wr_byte;
    logic [BW-1:0] reg_val;
    logic          rd_done;
    logic [BW-1:0] rd_data;
    logic          unused_ok;

    assign acc_rd    = cpu_rd && !cpu_wait;
    assign acc_wr    = cpu_wr && !cpu_wait;
    assign wr_byte   = cpu_word ? cpu_wdata[DATA_W-1:BW] : cpu_wdata[BW-1:0];
    assign unused_ok = open_bus[0];

    cop_ctl_decode #(
        .OFS_W      (OFS_W),
        .BUSREQ_OFS (BUSREQ_OFS),
        .RESET_OFS  (RESET_OFS)
    ) u_decode (
        .reg_space (cpu_addr[ADDR_W-1]),
        .ofs       (cpu_addr[OFS_W-1:0]),
        .sel       (sel)
    );

    cop_ctl_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_busreq (acc_wr && sel == SEL_BUSREQ),
        .ld_reset  (acc_wr && sel == SEL_RESET),
        .bit_in    (wr_byte[0]),
        .busreq    (cop_busreq),
        .reset_n   (cop_reset_n)
    );

    cop_ctl_window #(
        .AW (WAW),
        .DW (BW)
    ) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_rd   (acc_rd && sel == SEL_WIN),
        .start_wr   (acc_wr && sel == SEL_WIN),
        .start_addr (cpu_addr[WAW-1:0]),
        .start_data (wr_byte),
        .busack     (cop_busack),
        .win_rdata  (win_rdata),
        .cpu_wait   (cpu_wait),
        .win_rd     (win_rd),
        .win_wr     (win_wr),
        .win_addr   (win_addr),
        .win_wdata  (win_wdata),
        .rd_done    (rd_done),
        .rd_data    (rd_data)
    );

    // form the register read value for the selected offset
    always_comb begin
        case (sel)
            SEL_BUSREQ:  reg_val = {open_bus[BW-1:1], ~cop_busack};
            SEL_RESET:   reg_val = {{(BW-1){1'b0}}, cop_reset_n};
            SEL_VERSION: reg_val = VERSION_BYTE;
            default:     reg_val = {BW{1'b1}};
        endcase
    end

    // register the read data from either the register space or the window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_rdata <= {BW{1'b1}};
        end else if (acc_rd && sel != SEL_WIN) begin
            cpu_rdata <= reg_val;
        end else if (rd_done) begin
            cpu_rdata <= rd_data;
        end
    end
endmodule

// File: rtl/cop_ctl_chk.sv
// Checker: timing and gating properties of cop_ctl, bound to every instance.
module cop_ctl_chk #(
    parameter int               ADDR_W     = 17,
    parameter int               OFS_W      = 13,
    parameter logic [OFS_W-1:0] BUSREQ_OFS = 13'h1100,
    parameter logic [OFS_W-1:0] RESET_OFS  = 13'h1200
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [15:0]       cpu_wdata,
    input logic              cpu_word,
    input logic              cpu_rd,
    input logic              cpu_wr,
    input logic              cop_busack,
    input logic              cop_busreq,
    input logic              cop_reset_n,
    input logic              cpu_wait,
    input logic              win_rd,
    input logic              win_wr
);
    logic sel_bit;
    logic reg_wr;
    logic win_go;

    assign sel_bit = cpu_word ? cpu_wdata[8] : cpu_wdata[0];
    assign reg_wr  = cpu_wr && !cpu_wait && cpu_addr[ADDR_W-1];
    assign win_go  = (cpu_rd || cpu_wr) && !cpu_wait && !cpu_addr[ADDR_W-1];

    // R1
    rst_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!cop_busreq && !cop_reset_n && !cpu_wait && !win_rd && !win_wr));

    // R2
    busreq_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && cpu_addr[OFS_W-1:0] == BUSREQ_OFS) |=> (cop_busreq == $past(sel_bit)));

    // R3
    reset_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && cpu_addr[OFS_W-1:0] == RESET_OFS) |=> (cop_reset_n == $past(sel_bit)));

    // R10
    wait_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_go |=> cpu_wait);

    // R10
    wait_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wait |=> !cpu_wait);

    // R12
    grant_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_rd || win_wr) |-> $past(cop_busack));

    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({win_rd, win_wr}));
endmodule

bind cop_ctl cop_ctl_chk #(
    .ADDR_W     (ADDR_W),
    .OFS_W      (OFS_W),
    .BUSREQ_OFS (BUSREQ_OFS),
    .RESET_OFS  (RESET_OFS)
) u_cop_ctl_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_addr    (cpu_addr),
    .cpu_wdata   (cpu_wdata),
    .cpu_word    (cpu_word),
    .cpu_rd      (cpu_rd),
    .cpu_wr      (cpu_wr),
    .cop_busack  (cop_busack),
    .cop_busreq  (cop_busreq),
    .cop_reset_n (cop_reset_n),
    .cpu_wait    (cpu_wait),
    .win_rd      (win_rd),
    .win_wr      (win_wr)
);

// File: tb/cop_ctl_bench.sv
// Bench: directed corner cases, then seeded random traffic, checked against a model.
module cop_ctl_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [16:0] cpu_addr;
    logic [15:0] cpu_wdata;
    logic        cpu_word;
    logic        cpu_rd;
    logic        cpu_wr;
    logic        cop_busack;
    logic [7:0]  open_bus;
    logic [7:0]  win_rdata;
    logic        cop_busreq;
    logic        cop_reset_n;
    logic [7:0]  cpu_rdata;
    logic        cpu_wait;
    logic        win_rd;
    logic        win_wr;
    logic [15:0] win_addr;
    logic [7:0]  win_wdata;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;
    bit  m_busreq;
    bit  m_reset_n;

    always #5 clk = ~clk;

    assign win_rdata = win_addr[7:0] ^ 8'hA5;

    cop_ctl u_cop_ctl (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_word(cpu_word), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cop_busack(cop_busack), .open_bus(open_bus), .win_rdata(win_rdata),
        .cop_busreq(cop_busreq), .cop_reset_n(cop_reset_n), .cpu_rdata(cpu_rdata),
        .cpu_wait(cpu_wait), .win_rd(win_rd), .win_wr(win_wr),
        .win_addr(win_addr), .win_wdata(win_wdata)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] lane(input logic [15:0] d, input bit word);
        return word ? d[15:8] : d[7:0];
    endfunction

    function automatic logic [7:0] exp_reg_read(input logic [12:0] ofs, input bit ack,
                                                input logic [7:0] ob);
        if (ofs == 13'h1100)       return {ob[7:1], ~ack};
        else if (ofs == 13'h1200)  return {7'b0, m_reset_n};
        else if (ofs[12:1] == '0)  return 8'hA0;
        else                       return 8'hFF;
    endfunction

    // one strobe: driven at a falling edge, returns at the next falling edge
    task automatic strobe(input bit is_wr, input logic [16:0] a, input logic [15:0] d,
                          input bit word);
        cpu_addr = a; cpu_wdata = d; cpu_word = word;
        cpu_rd = !is_wr; cpu_wr = is_wr;
        @(negedge clk);
        cpu_rd = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic reg_op(input bit is_wr, input logic [2:0] hi, input logic [12:0] ofs,
                          input logic [15:0] d, input bit word, input bit ack,
                          input logic [7:0] ob, input string req);
        logic [7:0] exp;
        cop_busack = ack; open_bus = ob;
        exp = exp_reg_read(ofs, ack, ob);
        strobe(is_wr, {1'b1, hi, ofs}, d, word);
        if (is_wr) begin
            if (ofs == 13'h1100) m_busreq  = lane(d, word)[0];
            if (ofs == 13'h1200) m_reset_n = lane(d, word)[0];
            chk({req, " busreq"},  {15'b0, cop_busreq},  {15'b0, m_busreq});
            chk({req, " reset_n"}, {15'b0, cop_reset_n}, {15'b0, m_reset_n});
        end else begin
            chk({req, " rdata"}, {8'b0, cpu_rdata}, {8'b0, exp});
        end
    endtask

    task automatic win_op(input bit is_wr, input logic [15:0] a, input logic [15:0] d,
                          input bit word, input bit ack, input string req);
        cop_busack = ack;
        strobe(is_wr, {1'b0, a}, d, word);
        chk({req, " R10 wait"}, {15'b0, cpu_wait}, 16'd1);
        chk({req, " win_wr"}, {15'b0, win_wr}, {15'b0, is_wr && ack});
        chk({req, " win_rd"}, {15'b0, win_rd}, {15'b0, !is_wr && ack});
        if (ack) begin
            chk({req, " R11 addr"}, win_addr, a);
            if (is_wr) chk({req, " R4 wdata"}, {8'b0, win_wdata}, {8'b0, lane(d, word)});
        end
        @(negedge clk);
        chk({req, " R10 wait low"}, {15'b0, cpu_wait}, 16'd0);
        if (!is_wr)
            chk({req, " rdata"}, {8'b0, cpu_rdata}, ack ? {8'b0, a[7:0] ^ 8'hA5} : 16'h00FF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog expired actual=running expected=done");
            $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5EED;
        void'($urandom(seed));
        rst_n = 1'b0; cpu_addr = '0; cpu_wdata = '0; cpu_word = 1'b0;
        cpu_rd = 1'b0; cpu_wr = 1'b0; cop_busack = 1'b0; open_bus = 8'h00;
        m_busreq = 1'b0; m_reset_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: state right after reset
        chk("R1 busreq",  {15'b0, cop_busreq},  16'd0);
        chk("R1 reset_n", {15'b0, cop_reset_n}, 16'd0);
        chk("R1 wait",    {15'b0, cpu_wait},    16'd0);
        chk("R1 strobes", {14'b0, win_rd, win_wr}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);

        reg_op(0, 3'd0, 13'h1200, 16'h0, 0, 0, 8'h00, "R6 reset held");
        reg_op(1, 3'd0, 13'h1200, 16'h0001, 0, 0, 8'h00, "R3 release");
        reg_op(0, 3'd0, 13'h1200, 16'h0, 0, 0, 8'h00, "R6 reset released");
        reg_op(1, 3'd0, 13'h1200, 16'h00FE, 0, 0, 8'h00, "R3 assert");
        reg_op(1, 3'd0, 13'h1100, 16'h0001, 0, 0, 8'h00, "R2 request");
        reg_op(0, 3'd0, 13'h1100, 16'h0, 0, 0, 8'hC3, "R5 no grant");
        reg_op(0, 3'd0, 13'h1100, 16'h0, 0, 1, 8'hC3, "R5 granted");
        reg_op(1, 3'd0, 13'h1100, 16'h0001, 1, 0, 8'h00, "R4 word low bit");
        reg_op(1, 3'd0, 13'h1100, 16'h0100, 1, 0, 8'h00, "R4 word upper bit");
        reg_op(1, 3'd0, 13'h1100, 16'h0100, 0, 0, 8'h00, "R4 byte ignores bit8");
        reg_op(0, 3'd0, 13'h0000, 16'h0, 0, 0, 8'h00, "R7 version even");
        reg_op(0, 3'd0, 13'h0001, 16'h0, 0, 0, 8'h00, "R7 version odd");
        reg_op(0, 3'd0, 13'h0080, 16'h0, 0, 0, 8'h00, "R8 low unmapped");
        reg_op(0, 3'd0, 13'h1000, 16'h0, 0, 0, 8'h00, "R8 high unmapped");
        reg_op(1, 3'd0, 13'h1101, 16'h0001, 0, 0, 8'h00, "R8 write unmapped");
        reg_op(1, 3'd7, 13'h1100, 16'h0001, 0, 0, 8'h00, "R9 alias request");
        reg_op(1, 3'd5, 13'h1200, 16'h0001, 0, 0, 8'h00, "R9 alias release");
        win_op(0, 16'h1234, 16'h0, 0, 0, "R12 read no grant");
        win_op(1, 16'h0042, 16'h0077, 0, 0, "R12 write no grant");
        win_op(0, 16'hFFFF, 16'h0, 0, 1, "R11 read granted");
        win_op(1, 16'h8001, 16'h9955, 1, 1, "R11 word write granted");
        win_op(1, 16'h0003, 16'h9955, 0, 1, "R11 byte write granted");

        for (int i = 0; i < 400; i++) begin
            int unsigned k;
            logic [12:0] ofs;
            k = $urandom_range(0, 6);
            case (k)
                0: ofs = 13'h1100;
                1: ofs = 13'h1200;
                2: ofs = {12'b0, 1'($urandom)};
                default: ofs = 13'($urandom);
            endcase
            if (k >= 5)
                win_op(1'($urandom), 16'($urandom), 16'($urandom), 1'($urandom),
                       1'($urandom), "R11 R12 random window");
            else
                reg_op(1'($urandom), 3'($urandom), ofs, 16'($urandom), 1'($urandom),
                       1'($urandom), 8'($urandom), "R2 R3 R5 R8 random register");
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule